// File: doc/BRIEF.md
# Trace Cache with Path-Matched Lookup and Retirement Fill

The block holds recently executed instruction sequences, each of which may cross taken branches, so that the front end can receive up to several basic blocks in a single fetch. Fetch presents a start address and a vector of predicted branch directions. A stored trace whose start address agrees supplies its instructions, a per-slot valid mask and the address at which fetch resumes. When no stored trace starts at that address, the block reports a miss and fetch falls back to the ordinary instruction cache.

Matching follows the predicted path. If every recorded direction of the trace's internal branches agrees with the prediction, the whole trace is delivered. If one disagrees, only the leading part of the trace up to and including that branch is delivered, and fetch resumes on the predicted side of that branch. A fill engine gathers retired instructions in program order and commits a finished trace in one write. A trace is finished when it holds the slot limit or its branch limit. The write replaces whatever line sat at that index.

Top module: `trace_cache`

## Requirements
- R1: After reset no line is valid, the response outputs are all zero, and a lookup misses.
- R2: A lookup presented with `lk_valid` high in one cycle produces exactly one response with `rsp_valid` high in the next cycle, and `rsp_valid` stays low otherwise.
- R3: A lookup misses when the line at index `lk_addr[5:0]` is invalid or its stored tag differs from `lk_addr[15:6]`. A miss gives `rsp_hit`=0, `rsp_full`=0, mask zero and `rsp_next` zero.
- R4: A full hit needs a tag match and agreement between `lk_pred[k]` and the recorded direction of the trace's branch k (1 = taken), for each recorded branch with k below 2. It sets `rsp_full` and marks every filled slot valid.
- R5: On a tag match where branch k is the lowest-numbered disagreeing branch (k below 2), the mask covers slots 0 up to that branch's slot, `rsp_full` is 0, and `rsp_next` is the branch target if `lk_pred[k]` is 1, else the branch address plus one.
- R6: On a full hit, if the trace ends with its third branch, `lk_pred[2]` selects that branch's target (1) or its address plus one (0). Otherwise `rsp_next` is the address after the trace's last instruction.
- R7: The fill engine closes a trace after 16 retired instructions, including traces with no branch; the result is a 16-slot full hit.
- R8: The fill engine closes a trace at its third retired branch. The next retired instruction starts a new trace.
- R9: A committed trace replaces any earlier line at the same index, so lookups for the earlier start address then miss.
- R10: A lookup in the same cycle as a trace commit sees the line contents from before the commit; the following lookup sees the new trace.
- R11: Response slot i occupies `rsp_instr[i*32 +: 32]` and holds the i-th retired instruction of the trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 16 | Fetch start address (instruction units) |
| lk_pred | input | 3 | Predicted directions, bit k for branch k |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Some prefix of a trace is supplied |
| rsp_full | output | 1 | The whole trace matched the predicted path |
| rsp_mask | output | 16 | Usable instruction slots |
| rsp_instr | output | 512 | Sixteen 32-bit instruction slots |
| rsp_next | output | 16 | Address at which fetch resumes |
| ret_valid | input | 1 | Retired instruction this cycle |
| ret_pc | input | 16 | Address of the retired instruction |
| ret_instr | input | 32 | Retired instruction word |
| ret_branch | input | 1 | The retired instruction is a conditional branch |
| ret_taken | input | 1 | Resolved direction of that branch |
| ret_target | input | 16 | Taken target of that branch |

## Verification
The bench searches the predicted-direction space of a three-branch trace. It checks that a first-branch and a second-branch disagreement each cut the mask right after the branch and steer to the correct side; a design that picked the wrong side or counted slots off by one would send fetch down the wrong path. The third-branch direction must steer only the resume address. Slot-limit closure is tested with a branch-free run and with a two-branch trace, since a design that waited for a third branch would merge unrelated traces. A commit that coincides with a lookup exposes any write-before-read forwarding. A commit to an occupied index must evict the old line, or a stale trace would keep hitting.

// File: rtl/trace_cache.sv
module trace_cache #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 16,
  parameter int BLOCKS  = 3,
  parameter int LINES   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [ADDR_W-1:0]          lk_addr,
  input  logic [BLOCKS-1:0]          lk_pred,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_full,
  output logic [SLOTS-1:0]           rsp_mask,
  output logic [SLOTS*INSTR_W-1:0]   rsp_instr,
  output logic [ADDR_W-1:0]          rsp_next,
  input  logic                       ret_valid,
  input  logic [ADDR_W-1:0]          ret_pc,
  input  logic [INSTR_W-1:0]         ret_instr,
  input  logic                       ret_branch,
  input  logic                       ret_taken,
  input  logic [ADDR_W-1:0]          ret_target
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SL_W  = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int BI_W  = $clog2(BLOCKS);
  localparam int BC_W  = $clog2(BLOCKS + 1);

  typedef struct packed {
    logic [TAG_W-1:0]                tag;
    logic [SLOTS-1:0][INSTR_W-1:0]   instr;
    logic [CNT_W-1:0]                len;
    logic [BC_W-1:0]                 nbr;
    logic [BLOCKS-1:0]               flag;
    logic [BLOCKS-1:0][SL_W-1:0]     pos;
    logic [BLOCKS-1:0][ADDR_W-1:0]   ft;
    logic [BLOCKS-1:0][ADDR_W-1:0]   tgt;
    logic [ADDR_W-1:0]               nseq;
  } line_t;

  line_t             mem [LINES];
  logic [LINES-1:0]  vld;

  // lookup path
  logic [IDX_W-1:0]  lk_idx;
  line_t             rd;
  logic              tag_ok;
  logic              miss_br;
  logic [BI_W-1:0]   mk;
  logic [SL_W-1:0]   last_slot;
  logic [ADDR_W-1:0] nxt;
  logic [SLOTS-1:0]  mask;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign rd     = mem[lk_idx];
  assign tag_ok = vld[lk_idx] && (rd.tag == lk_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    miss_br = 1'b0;
    mk      = '0;
    for (int k = 0; k < BLOCKS - 1; k++)
      if (!miss_br && k < int'(rd.nbr) && lk_pred[k] != rd.flag[k]) begin
        miss_br = 1'b1;
        mk      = BI_W'(k);
      end
    if (miss_br) begin
      last_slot = rd.pos[mk];
      nxt       = lk_pred[mk] ? rd.tgt[mk] : rd.ft[mk];
    end else begin
      last_slot = SL_W'(rd.len - 1'b1);
      if (int'(rd.nbr) == BLOCKS)
        nxt = lk_pred[BLOCKS-1] ? rd.tgt[BLOCKS-1] : rd.ft[BLOCKS-1];
      else
        nxt = rd.nseq;
    end
    for (int i = 0; i < SLOTS; i++) mask[i] = (i <= int'(last_slot));
  end

  wire lk_hit = lk_valid && tag_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_full  <= 1'b0;
      rsp_mask  <= '0;
      rsp_instr <= '0;
      rsp_next  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_full  <= lk_hit && !miss_br;
      rsp_mask  <= lk_hit ? mask : '0;
      rsp_instr <= lk_hit ? rd.instr : '0;
      rsp_next  <= lk_hit ? nxt : '0;
    end
  end

  // fill path
  line_t             fb, nb;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] start, st_now;
  logic              done;

  always_comb begin
    nb = fb;
    nb.instr[cnt[SL_W-1:0]] = ret_instr;
    nb.len  = cnt + 1'b1;
    nb.nseq = ret_pc + 1'b1;
    if (ret_branch) begin
      nb.flag[fb.nbr[BI_W-1:0]] = ret_taken;
      nb.pos[fb.nbr[BI_W-1:0]]  = cnt[SL_W-1:0];
      nb.ft[fb.nbr[BI_W-1:0]]   = ret_pc + 1'b1;
      nb.tgt[fb.nbr[BI_W-1:0]]  = ret_target;
      nb.nbr = fb.nbr + 1'b1;
    end
    st_now = (cnt == '0) ? ret_pc : start;
    nb.tag = st_now[ADDR_W-1:IDX_W];
    done   = ret_valid && (int'(cnt) == SLOTS - 1 ||
                           (ret_branch && int'(fb.nbr) == BLOCKS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fb    <= '0;
      start <= '0;
      vld   <= '0;
    end else if (ret_valid) begin
      if (done) begin
        cnt <= '0;
        fb  <= '0;
        vld[st_now[IDX_W-1:0]] <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        fb    <= nb;
        start <= st_now;
      end
    end
  end

  always_ff @(posedge clk)
    if (done) mem[st_now[IDX_W-1:0]] <= nb;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_miss_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_mask == '0 && rsp_next == '0 && !rsp_full));
  assert_full_is_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |-> rsp_hit);
  assert_mask_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_mask[0] && ((rsp_mask & (rsp_mask + 1'b1)) == '0)));
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < SLOTS && int'(fb.nbr) < BLOCKS);
endmodule

// File: tb/trace_cache_tb_top.sv
module trace_cache_tb_top;
  localparam int AW = 16;
  localparam int IW = 32;
  localparam int NS = 16;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid;
  logic [AW-1:0] lk_addr;
  logic [NB-1:0] lk_pred;
  logic rsp_valid, rsp_hit, rsp_full;
  logic [NS-1:0] rsp_mask;
  logic [NS*IW-1:0] rsp_instr;
  logic [AW-1:0] rsp_next;
  logic ret_valid;
  logic [AW-1:0] ret_pc;
  logic [IW-1:0] ret_instr;
  logic ret_branch, ret_taken;
  logic [AW-1:0] ret_target;

  always #4 clk = ~clk;

  trace_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_pred(lk_pred),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_full(rsp_full),
    .rsp_mask(rsp_mask), .rsp_instr(rsp_instr), .rsp_next(rsp_next),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_instr(ret_instr),
    .ret_branch(ret_branch), .ret_taken(ret_taken), .ret_target(ret_target)
  );

  typedef struct {
    bit          hit;
    bit          full;
    logic [15:0] mask;
    logic [15:0] nxt;
    int          tid;
    string       req;
  } exp_t;

  exp_t sb[$];
  exp_t e;
  int vecs = 0;
  int errs = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) check(1'b0, "R2", "unexpected response", 1, 0);
      else begin
        e = sb.pop_front();
        check(rsp_hit == e.hit, e.req, "hit", rsp_hit, e.hit);
        check(rsp_full == e.full, e.req, "full", rsp_full, e.full);
        check(rsp_mask == e.mask, e.req, "mask", rsp_mask, e.mask);
        check(rsp_next == e.nxt, e.req, "next", rsp_next, e.nxt);
        for (int i = 0; i < NS; i++)
          if (e.mask[i])
            check(rsp_instr[i*IW+16 +: 16] == {8'(e.tid), 8'(i)}, "R11", "slot word",
                  rsp_instr[i*IW+16 +: 16], {8'(e.tid), 8'(i)});
      end
    end
  end

  function automatic exp_t mk(input bit h, input bit f, input logic [15:0] m,
                              input logic [15:0] n, input int t, input string r);
    exp_t x;
    x.hit = h; x.full = f; x.mask = m; x.nxt = n; x.tid = t; x.req = r;
    return x;
  endfunction

  task automatic lookup(input logic [AW-1:0] a, input logic [NB-1:0] p, input exp_t x);
    sb.push_back(x);
    lk_valid = 1'b1; lk_addr = a; lk_pred = p;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic set_ret(input logic [AW-1:0] pc, input int tid, input int slot,
                         input bit br, input bit tk, input logic [AW-1:0] tg);
    ret_valid = 1'b1; ret_pc = pc; ret_instr = {8'(tid), 8'(slot), pc};
    ret_branch = br; ret_taken = tk; ret_target = tg;
  endtask

  task automatic retire(input logic [AW-1:0] pc, input int tid, input int slot,
                        input bit br, input bit tk, input logic [AW-1:0] tg);
    set_ret(pc, tid, slot, br, tk, tg);
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0; lk_pred = '0;
    ret_valid = 1'b0; ret_pc = '0; ret_instr = '0;
    ret_branch = 1'b0; ret_taken = 1'b0; ret_target = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R1", "reset flags", {rsp_valid, rsp_hit}, 0);
    check(rsp_mask == '0 && rsp_next == '0, "R1", "reset data", rsp_mask, 0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup(16'h0100, 3'b101, mk(0, 0, 16'h0, 16'h0, 0, "R1"));

    // trace 1: three branches, closes at the third (R8)
    retire(16'h0100, 1, 0, 0, 0, 16'h0);
    retire(16'h0101, 1, 1, 1, 1, 16'h0200);
    retire(16'h0200, 1, 2, 0, 0, 16'h0);
    retire(16'h0201, 1, 3, 0, 0, 16'h0);
    retire(16'h0202, 1, 4, 1, 0, 16'h0250);
    retire(16'h0203, 1, 5, 0, 0, 16'h0);
    retire(16'h0204, 1, 6, 1, 1, 16'h0300);
    lookup(16'h0100, 3'b101, mk(1, 1, 16'h007F, 16'h0300, 1, "R8"));
    lookup(16'h0100, 3'b001, mk(1, 1, 16'h007F, 16'h0205, 1, "R6"));
    lookup(16'h0100, 3'b101, mk(1, 1, 16'h007F, 16'h0300, 1, "R4"));
    lookup(16'h0100, 3'b000, mk(1, 0, 16'h0003, 16'h0102, 1, "R5"));
    lookup(16'h0100, 3'b111, mk(1, 0, 16'h001F, 16'h0250, 1, "R5"));
    lookup(16'h0140, 3'b101, mk(0, 0, 16'h0, 16'h0, 0, "R3"));
    lookup(16'h0105, 3'b101, mk(0, 0, 16'h0, 16'h0, 0, "R3"));

    // trace 2: sixteen plain instructions at the same index (R7, R9, R10)
    for (int i = 0; i < NS - 1; i++) retire(16'h0480 + 16'(i), 2, i, 0, 0, 16'h0);
    sb.push_back(mk(1, 1, 16'h007F, 16'h0300, 1, "R10"));
    lk_valid = 1'b1; lk_addr = 16'h0100; lk_pred = 3'b101;
    set_ret(16'h048F, 2, 15, 0, 0, 16'h0);
    @(negedge clk);
    lk_valid = 1'b0; ret_valid = 1'b0;
    lookup(16'h0100, 3'b101, mk(0, 0, 16'h0, 16'h0, 0, "R9"));
    lookup(16'h0480, 3'b111, mk(1, 1, 16'hFFFF, 16'h0490, 2, "R7"));

    // trace 3: two branches, closed by the slot limit
    retire(16'h0207, 3, 0, 1, 1, 16'h0300);
    for (int i = 1; i < NS; i++)
      retire(16'h0300 + 16'(i - 1), 3, i, (i == 5), 0, 16'h03F0);
    lookup(16'h0207, 3'b001, mk(1, 1, 16'hFFFF, 16'h030F, 3, "R6"));
    lookup(16'h0207, 3'b101, mk(1, 1, 16'hFFFF, 16'h030F, 3, "R6"));
    lookup(16'h0207, 3'b011, mk(1, 0, 16'h003F, 16'h03F0, 3, "R5"));
    lookup(16'h0207, 3'b000, mk(1, 0, 16'h0001, 16'h0208, 3, "R5"));
    lookup(16'h0107, 3'b001, mk(0, 0, 16'h0, 16'h0, 0, "R3"));

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "pending responses", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule